// File: doc/BRIEF.md
# GPIO Bank with Sleep-Force Pin Override

This block is a bank of 32 general-purpose I/O lines controlled through a small memory-mapped register bus. Every line carries a stored data bit, a direction bit, a pull-disable bit, a two-bit function select and a sleep-keep bit. The function select hands the pad either to the bank's own GPIO logic or to one of three peripheral functions, each modelled as an output-value and output-enable vector at the block's ports. Pin levels pass through a synchronizer. Rising and falling edges are then detected and collected into a sticky interrupt status and a separate sticky wake status.

A global force input, raised by the power controller around sleep, overrides pin ownership line by line. While force is high, a line whose sleep-keep bit is 0 is taken over as a GPIO input with wake detection armed, whatever its function select. A line whose sleep-keep bit is 1 stays under its normal owner and does not take part in wake detection. When force drops, every line goes back to the function its select bits name.

Top module: `gpio_bank_slpforce`

## Requirements
- R1: After reset every configuration, mask and status register reads 0, every pad output enable is 0, every pad pull is enabled with pull-down selected, and irq and wake_irq are 0.
- R2: Byte offset 0x00 writes the stored data bits, 0x04 sets the data bits written as 1 and 0x08 clears them. Offset 0x10 writes direction (1 = output) and reads it back, 0x14 sets direction bits and 0x18 clears them. A 0 bit in any set or clear write leaves that bit unchanged.
- R3: With force low, each line's function code is {select B bit (offset 0x24), select A bit (offset 0x20)}. Code 0 drives the pad from the stored data bit with enable = direction bit. Codes 1, 2 and 3 drive the pad from peripheral A, B and C.
- R4: While sleep_force is 1, a line whose sleep-keep bit (offset 0x1C) is 0 has pad_oe 0 and pad_out equal to its data bit, whatever its function code and direction.
- R5: While sleep_force is 1, a line whose sleep-keep bit is 1 is driven exactly as under R3.
- R6: When sleep_force returns to 0, every line is again driven as R3 gives, on the same cycle.
- R7: pad_pull_en of a line is 1 exactly when its pad_oe is 0 and its pull-disable bit (offset 0x0C) is 0. pad_pull_up equals the line's data bit (1 = pull-up, 0 = pull-down).
- R8: A rising edge of the synchronized pin on a line whose rise-enable bit (0x40) is 1, or a falling edge on a line whose fall-enable bit (0x44) is 1, sets that line's interrupt status bit (read at 0x48) three clock edges after the pin changes. irq is 1 whenever any status bit is 1.
- R9: Writing 1 to a bit at 0x4C clears that interrupt status bit. A qualifying edge on the same clock edge keeps the bit set. Status bits are never cleared any other way.
- R10: The wake status (read at 0x58) of a line is set by a rising edge with wake-rise enable (0x50) or a falling edge with wake-fall enable (0x54), only while sleep_force is 1 and the line's sleep-keep bit is 0. Writing 1 to a bit at 0x58 clears it. wake_irq is the OR of the wake status bits.
- R11: Reading 0x00 returns the pin levels after the two-stage synchronizer. Reads of the set and clear offsets (0x04, 0x08, 0x14, 0x18, 0x4C) and of unmapped offsets return 0.
- R12: pad_slow reflects the low-EMI register at offset 0x28, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| pin_in | input | 32 | Pad input levels, asynchronous |
| sleep_force | input | 1 | Sleep override request |
| alt_a_out | input | 32 | Peripheral A output values |
| alt_a_oe | input | 32 | Peripheral A output enables |
| alt_b_out | input | 32 | Peripheral B output values |
| alt_b_oe | input | 32 | Peripheral B output enables |
| alt_c_out | input | 32 | Peripheral C output values |
| alt_c_oe | input | 32 | Peripheral C output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pad pull resistor enables |
| pad_pull_up | output | 32 | Pad pull direction, 1 = up |
| pad_slow | output | 32 | Pad low-EMI (slow edge) controls |
| irq | output | 1 | OR of interrupt status |
| wake_irq | output | 1 | OR of wake status |

## Verification
Two functions of this block can meet on one clock edge. The first pair is a software clear of an interrupt or wake status bit and a fresh qualifying edge on the same line. The second pair is the force input changing while the function select is rewritten. The bench provokes the first case directly: it lands the clear write on exactly the clock edge at which the synchronized pin edge arrives, and it requires the status bit to read back as still set. The second case comes from random register writes mixed with random toggling of sleep_force. After each step the bench compares every pad output against a model of the ownership rules.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int GPB_LINES = 32;
    localparam int GPB_AW    = 8;

    typedef logic [GPB_LINES-1:0] lvec_t;

    // register byte offsets
    localparam logic [GPB_AW-1:0] OFS_DATA      = 8'h00;
    localparam logic [GPB_AW-1:0] OFS_DSET      = 8'h04;
    localparam logic [GPB_AW-1:0] OFS_DCLR      = 8'h08;
    localparam logic [GPB_AW-1:0] OFS_NOPULL    = 8'h0C;
    localparam logic [GPB_AW-1:0] OFS_DIR       = 8'h10;
    localparam logic [GPB_AW-1:0] OFS_DIRSET    = 8'h14;
    localparam logic [GPB_AW-1:0] OFS_DIRCLR    = 8'h18;
    localparam logic [GPB_AW-1:0] OFS_KEEP      = 8'h1C;
    localparam logic [GPB_AW-1:0] OFS_SELA      = 8'h20;
    localparam logic [GPB_AW-1:0] OFS_SELB      = 8'h24;
    localparam logic [GPB_AW-1:0] OFS_SLOW      = 8'h28;
    localparam logic [GPB_AW-1:0] OFS_RISE_EN   = 8'h40;
    localparam logic [GPB_AW-1:0] OFS_FALL_EN   = 8'h44;
    localparam logic [GPB_AW-1:0] OFS_IRQ_STAT  = 8'h48;
    localparam logic [GPB_AW-1:0] OFS_IRQ_CLR   = 8'h4C;
    localparam logic [GPB_AW-1:0] OFS_WRISE_EN  = 8'h50;
    localparam logic [GPB_AW-1:0] OFS_WFALL_EN  = 8'h54;
    localparam logic [GPB_AW-1:0] OFS_WAKE_STAT = 8'h58;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_A    = 2'd1,
        FN_B    = 2'd2,
        FN_C    = 2'd3
    } fn_e;

    typedef struct packed {
        lvec_t data;
        lvec_t nopull;
        lvec_t dir;
        lvec_t keep;
        lvec_t sel_a;
        lvec_t sel_b;
        lvec_t slow;
    } pin_cfg_t;

    typedef struct packed {
        lvec_t rise_en;
        lvec_t fall_en;
        lvec_t wrise_en;
        lvec_t wfall_en;
    } evt_cfg_t;

    typedef struct packed {
        lvec_t out;
        lvec_t oe;
    } drive_t;

    function automatic fn_e line_fn(input logic sel_b, input logic sel_a);
        return fn_e'({sel_b, sel_a});
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync
    import gpb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  lvec_t pin_in,
    output lvec_t lvl,
    output lvec_t rise,
    output lvec_t fall
);

    localparam int TOP = STAGES - 1;

    lvec_t prev_q;

    for (genvar i = 0; i < GPB_LINES; i++) begin : g_line
        logic [TOP:0] chain_q;
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin_in[i];
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[TOP-1:0], pin_in[i]};
            end
        end
        assign lvl[i] = chain_q[TOP];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [GPB_AW-1:0] bus_addr,
    input  lvec_t             bus_wdata,
    output lvec_t             bus_rdata,
    input  lvec_t             pin_lvl,
    input  lvec_t             irq_stat,
    input  lvec_t             wake_stat,
    output pin_cfg_t          cfg,
    output evt_cfg_t          ecfg,
    output lvec_t             irq_clr,
    output lvec_t             wake_clr
);

    logic wr_en;
    logic rd_en;

    assign wr_en = bus_valid && bus_we;
    assign rd_en = bus_valid && !bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            ecfg <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_DATA:     cfg.data     <= bus_wdata;
                OFS_DSET:     cfg.data     <= cfg.data | bus_wdata;
                OFS_DCLR:     cfg.data     <= cfg.data & ~bus_wdata;
                OFS_NOPULL:   cfg.nopull   <= bus_wdata;
                OFS_DIR:      cfg.dir      <= bus_wdata;
                OFS_DIRSET:   cfg.dir      <= cfg.dir | bus_wdata;
                OFS_DIRCLR:   cfg.dir      <= cfg.dir & ~bus_wdata;
                OFS_KEEP:     cfg.keep     <= bus_wdata;
                OFS_SELA:     cfg.sel_a    <= bus_wdata;
                OFS_SELB:     cfg.sel_b    <= bus_wdata;
                OFS_SLOW:     cfg.slow     <= bus_wdata;
                OFS_RISE_EN:  ecfg.rise_en  <= bus_wdata;
                OFS_FALL_EN:  ecfg.fall_en  <= bus_wdata;
                OFS_WRISE_EN: ecfg.wrise_en <= bus_wdata;
                OFS_WFALL_EN: ecfg.wfall_en <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign irq_clr  = (wr_en && bus_addr == OFS_IRQ_CLR)   ? bus_wdata : '0;
    assign wake_clr = (wr_en && bus_addr == OFS_WAKE_STAT) ? bus_wdata : '0;

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFS_DATA:      bus_rdata = pin_lvl;
                OFS_NOPULL:    bus_rdata = cfg.nopull;
                OFS_DIR:       bus_rdata = cfg.dir;
                OFS_KEEP:      bus_rdata = cfg.keep;
                OFS_SELA:      bus_rdata = cfg.sel_a;
                OFS_SELB:      bus_rdata = cfg.sel_b;
                OFS_SLOW:      bus_rdata = cfg.slow;
                OFS_RISE_EN:   bus_rdata = ecfg.rise_en;
                OFS_FALL_EN:   bus_rdata = ecfg.fall_en;
                OFS_IRQ_STAT:  bus_rdata = irq_stat;
                OFS_WRISE_EN:  bus_rdata = ecfg.wrise_en;
                OFS_WFALL_EN:  bus_rdata = ecfg.wfall_en;
                OFS_WAKE_STAT: bus_rdata = wake_stat;
                default:       bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpb_events.sv
module gpb_events
    import gpb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvec_t    rise,
    input  lvec_t    fall,
    input  evt_cfg_t ecfg,
    input  logic     sleep_force,
    input  lvec_t    keep,
    input  lvec_t    irq_clr,
    input  lvec_t    wake_clr,
    output lvec_t    irq_stat,
    output lvec_t    wake_stat,
    output lvec_t    wake_en
);

    lvec_t irq_hit;
    lvec_t wake_hit;

    assign wake_en  = sleep_force ? ~keep : '0;
    assign irq_hit  = (rise & ecfg.rise_en) | (fall & ecfg.fall_en);
    assign wake_hit = ((rise & ecfg.wrise_en) | (fall & ecfg.wfall_en)) & wake_en;

    // a new edge outranks a clear landing on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_stat  <= '0;
            wake_stat <= '0;
        end else begin
            irq_stat  <= (irq_stat & ~irq_clr) | irq_hit;
            wake_stat <= (wake_stat & ~wake_clr) | wake_hit;
        end
    end

endmodule

// File: rtl/gpb_padmux.sv
module gpb_padmux
    import gpb_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     sleep_force,
    input  drive_t   per_a,
    input  drive_t   per_b,
    input  drive_t   per_c,
    output lvec_t    pad_out,
    output lvec_t    pad_oe,
    output lvec_t    pad_pull_en,
    output lvec_t    pad_pull_up,
    output lvec_t    pad_slow
);

    for (genvar i = 0; i < GPB_LINES; i++) begin : g_line
        logic seized;
        fn_e  fn;

        assign seized = sleep_force && !cfg.keep[i];
        assign fn     = seized ? FN_GPIO : line_fn(cfg.sel_b[i], cfg.sel_a[i]);

        always_comb begin
            case (fn)
                FN_A: begin
                    pad_out[i] = per_a.out[i];
                    pad_oe[i]  = per_a.oe[i];
                end
                FN_B: begin
                    pad_out[i] = per_b.out[i];
                    pad_oe[i]  = per_b.oe[i];
                end
                FN_C: begin
                    pad_out[i] = per_c.out[i];
                    pad_oe[i]  = per_c.oe[i];
                end
                default: begin
                    pad_out[i] = cfg.data[i];
                    pad_oe[i]  = cfg.dir[i] && !seized;
                end
            endcase
        end

        assign pad_pull_en[i] = !pad_oe[i] && !cfg.nopull[i];
    end

    assign pad_pull_up = cfg.data;
    assign pad_slow    = cfg.slow;

endmodule

// File: rtl/gpio_bank_slpforce.sv
module gpio_bank_slpforce
    import gpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [GPB_AW-1:0]    bus_addr,
    input  logic [GPB_LINES-1:0] bus_wdata,
    output logic [GPB_LINES-1:0] bus_rdata,
    input  logic [GPB_LINES-1:0] pin_in,
    input  logic                 sleep_force,
    input  logic [GPB_LINES-1:0] alt_a_out,
    input  logic [GPB_LINES-1:0] alt_a_oe,
    input  logic [GPB_LINES-1:0] alt_b_out,
    input  logic [GPB_LINES-1:0] alt_b_oe,
    input  logic [GPB_LINES-1:0] alt_c_out,
    input  logic [GPB_LINES-1:0] alt_c_oe,
    output logic [GPB_LINES-1:0] pad_out,
    output logic [GPB_LINES-1:0] pad_oe,
    output logic [GPB_LINES-1:0] pad_pull_en,
    output logic [GPB_LINES-1:0] pad_pull_up,
    output logic [GPB_LINES-1:0] pad_slow,
    output logic                 irq,
    output logic                 wake_irq
);

    pin_cfg_t cfg;
    evt_cfg_t ecfg;
    lvec_t    pin_lvl;
    lvec_t    pin_rise;
    lvec_t    pin_fall;
    lvec_t    irq_stat;
    lvec_t    wake_stat;
    lvec_t    irq_clr;
    lvec_t    wake_clr;
    lvec_t    wake_en;
    drive_t   per_a;
    drive_t   per_b;
    drive_t   per_c;

    assign per_a = '{out: alt_a_out, oe: alt_a_oe};
    assign per_b = '{out: alt_b_out, oe: alt_b_oe};
    assign per_c = '{out: alt_c_out, oe: alt_c_oe};

    gpb_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .lvl    (pin_lvl),
        .rise   (pin_rise),
        .fall   (pin_fall)
    );

    gpb_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (pin_lvl),
        .irq_stat  (irq_stat),
        .wake_stat (wake_stat),
        .cfg       (cfg),
        .ecfg      (ecfg),
        .irq_clr   (irq_clr),
        .wake_clr  (wake_clr)
    );

    gpb_events events_i (
        .clk         (clk),
        .rst         (rst),
        .rise        (pin_rise),
        .fall        (pin_fall),
        .ecfg        (ecfg),
        .sleep_force (sleep_force),
        .keep        (cfg.keep),
        .irq_clr     (irq_clr),
        .wake_clr    (wake_clr),
        .irq_stat    (irq_stat),
        .wake_stat   (wake_stat),
        .wake_en     (wake_en)
    );

    gpb_padmux padmux_i (
        .cfg         (cfg),
        .sleep_force (sleep_force),
        .per_a       (per_a),
        .per_b       (per_b),
        .per_c       (per_c),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up),
        .pad_slow    (pad_slow)
    );

    assign irq      = |irq_stat;
    assign wake_irq = |wake_stat;

endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
    import gpb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [GPB_AW-1:0] bus_addr,
    input lvec_t             bus_wdata,
    input lvec_t             bus_rdata,
    input logic              sleep_force,
    input lvec_t             keep,
    input lvec_t             dir,
    input lvec_t             sel_a,
    input lvec_t             sel_b,
    input lvec_t             pad_oe,
    input lvec_t             pad_pull_en,
    input lvec_t             irq_stat,
    input lvec_t             wake_stat,
    input lvec_t             wake_en
);

    lvec_t clr_seen;
    logic  rd_unmapped;

    assign clr_seen = (bus_valid && bus_we && bus_addr == OFS_IRQ_CLR) ? bus_wdata : '0;
    assign rd_unmapped = bus_valid && !bus_we &&
                         (bus_addr == OFS_DSET || bus_addr == OFS_DCLR ||
                          bus_addr == OFS_DIRSET || bus_addr == OFS_DIRCLR ||
                          bus_addr == OFS_IRQ_CLR || bus_addr > OFS_WAKE_STAT ||
                          bus_addr[1:0] != 2'b00);

    // R4
    forced_input_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_force |-> ((pad_oe & ~keep) == '0));

    // R7
    pull_off_when_driving_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_pull_en & pad_oe) == '0));

    // R6
    gpio_dir_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_force |-> (((pad_oe ^ dir) & ~sel_a & ~sel_b) == '0));

    // R9
    irq_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((~irq_stat & $past(irq_stat) & ~$past(clr_seen)) == '0));

    // R10
    wake_only_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
        ((wake_stat & ~$past(wake_stat) & ~$past(wake_en)) == '0));

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |-> (bus_rdata == '0));

endmodule

bind gpio_bank_slpforce gpb_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sleep_force (sleep_force),
    .keep        (cfg.keep),
    .dir         (cfg.dir),
    .sel_a       (cfg.sel_a),
    .sel_b       (cfg.sel_b),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .irq_stat    (irq_stat),
    .wake_stat   (wake_stat),
    .wake_en     (wake_en)
);

// File: tb/gpio_bank_slpforce_tb.sv
`timescale 1ns/1ps
module gpio_bank_slpforce_tb_top;
    import gpb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic        sleep_force = 1'b0;
    logic [31:0] alt_a_out = '0, alt_a_oe = '0;
    logic [31:0] alt_b_out = '0, alt_b_oe = '0;
    logic [31:0] alt_c_out = '0, alt_c_oe = '0;
    logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_slow;
    logic        irq, wake_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of configuration
    logic [31:0] m_data = '0, m_nopull = '0, m_dir = '0, m_keep = '0;
    logic [31:0] m_sa = '0, m_sb = '0, m_slow = '0;

    always #2.5 clk = ~clk;

    gpio_bank_slpforce dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .sleep_force(sleep_force),
        .alt_a_out(alt_a_out), .alt_a_oe(alt_a_oe),
        .alt_b_out(alt_b_out), .alt_b_oe(alt_b_oe),
        .alt_c_out(alt_c_out), .alt_c_oe(alt_c_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .pad_slow(pad_slow),
        .irq(irq), .wake_irq(wake_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_data   = d;
            8'h04: m_data   = m_data | d;
            8'h08: m_data   = m_data & ~d;
            8'h0C: m_nopull = d;
            8'h10: m_dir    = d;
            8'h14: m_dir    = m_dir | d;
            8'h18: m_dir    = m_dir & ~d;
            8'h1C: m_keep   = d;
            8'h20: m_sa     = d;
            8'h24: m_sb     = d;
            8'h28: m_slow   = d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // expected pad drive from R3..R7
    function automatic logic [63:0] exp_drive();
        logic [31:0] o, e;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] code;
            code = (sleep_force && !m_keep[i]) ? 2'd0 : {m_sb[i], m_sa[i]};
            case (code)
                2'd1: begin o[i] = alt_a_out[i]; e[i] = alt_a_oe[i]; end
                2'd2: begin o[i] = alt_b_out[i]; e[i] = alt_b_oe[i]; end
                2'd3: begin o[i] = alt_c_out[i]; e[i] = alt_c_oe[i]; end
                default: begin
                    o[i] = m_data[i];
                    e[i] = m_dir[i] && !(sleep_force && !m_keep[i]);
                end
            endcase
        end
        return {o, e};
    endfunction

    task automatic chk_pads(input string tag);
        logic [63:0] x;
        x = exp_drive();
        check({tag, " R3 R4 R5 R6 pad_out"}, pad_out, x[63:32]);
        check({tag, " R3 R4 R5 R6 pad_oe"}, pad_oe, x[31:0]);
        check({tag, " R7 pull_en"}, pad_pull_en, ~x[31:0] & ~m_nopull);
        check({tag, " R7 pull_up"}, pad_pull_up, m_data);
        check({tag, " R12 slow"}, pad_slow, m_slow);
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : main
        logic [31:0] v;
        logic [7:0]  reg_list [12] = '{8'h0C, 8'h10, 8'h1C, 8'h20, 8'h24, 8'h28,
                                       8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58};
        logic [7:0]  cfg_ofs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                      8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};
        v = $urandom(32'h5EED_0042);
        settle(4);
        rst = 1'b0;

        // R1 reset state
        settle(1);
        #1;
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pull_en", pad_pull_en, '1);
        check("R1 pull_up", pad_pull_up, '0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 wake_irq", {31'd0, wake_irq}, 32'd0);
        foreach (reg_list[j]) begin
            rd(reg_list[j], v);
            check("R1 register", v, '0);
        end

        // R2 data and direction writes, sets and clears
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, 32'hA5A5_A5A5);
        wr(8'h04, 32'h0000_000F);
        wr(8'h08, 32'hA000_0000);
        #1 check("R2 data via pad_out", pad_out, 32'h05A5_A5AF);
        wr(8'h18, 32'h0000_FF00);
        wr(8'h14, 32'h0000_0100);
        rd(8'h10, v);
        check("R2 direction readback", v, 32'hFFFF_01FF);
        chk_pads("R2");

        // R3 function codes: line0 GPIO, 1 A, 2 B, 3 C
        alt_a_out = 32'h0000_0002; alt_a_oe = 32'h0000_0002;
        alt_b_out = 32'h0000_0000; alt_b_oe = 32'h0000_0004;
        alt_c_out = 32'h0000_0008; alt_c_oe = 32'h0000_0000;
        wr(8'h20, 32'h0000_000A);
        wr(8'h24, 32'h0000_000C);
        #1 chk_pads("R3 directed");

        // R4 forced lines become GPIO inputs; R5 kept line stays on peripheral
        wr(8'h1C, 32'h0000_0004);
        @(negedge clk);
        sleep_force = 1'b1;
        #1 chk_pads("R4 R5 directed");
        check("R4 line3 forced oe", {31'd0, pad_oe[3]}, 32'd0);
        check("R5 line2 kept on B", {31'd0, pad_oe[2]}, 32'd1);
        @(negedge clk);
        sleep_force = 1'b0;
        #1 chk_pads("R6 directed");
        check("R6 line1 back on A", {31'd0, pad_oe[1]}, 32'd1);

        // random configuration mixed with force toggling
        for (int it = 0; it < 80; it++) begin
            logic [7:0] a;
            a = cfg_ofs[$urandom_range(0, 10)];
            wr(a, $urandom());
            alt_a_out = $urandom(); alt_a_oe = $urandom();
            alt_b_out = $urandom(); alt_b_oe = $urandom();
            alt_c_out = $urandom(); alt_c_oe = $urandom();
            sleep_force = $urandom_range(0, 1) == 1;
            #1 chk_pads("random");
        end
        sleep_force = 1'b0;

        // R11 synchronized data read, two edges of latency
        @(negedge clk);
        pin_in = 32'h1234_5678;
        rd(8'h00, v);
        check("R11 data after one edge", v, 32'h0000_0000);
        rd(8'h00, v);
        check("R11 data after two edges", v, 32'h1234_5678);
        rd(8'h04, v); check("R11 set offset reads zero", v, '0);
        rd(8'h4C, v); check("R11 clear offset reads zero", v, '0);
        rd(8'h2C, v); check("R11 unmapped 0x2C", v, '0);
        rd(8'h3C, v); check("R11 unmapped 0x3C", v, '0);
        rd(8'h5C, v); check("R11 unmapped 0x5C", v, '0);
        @(negedge clk);
        pin_in = '0;
        settle(4);

        // R8 edge detection
        wr(8'h40, 32'h0000_0001);
        wr(8'h44, 32'h0000_0002);
        @(negedge clk);
        pin_in = 32'h0000_0003;
        settle(3);
        rd(8'h48, v);
        check("R8 rise sets line0 only", v, 32'h0000_0001);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        @(negedge clk);
        pin_in = 32'h0000_0000;
        settle(3);
        rd(8'h48, v);
        check("R8 fall sets line1", v, 32'h0000_0003);

        // R9 clear and clear-versus-edge on one edge
        wr(8'h4C, 32'h0000_0003);
        rd(8'h48, v);
        check("R9 cleared", v, 32'h0000_0000);
        check("R9 irq low", {31'd0, irq}, 32'd0);
        @(negedge clk);
        pin_in = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        rd(8'h48, v);
        check("R9 edge wins over clear", v, 32'h0000_0001);
        wr(8'h4C, 32'h0000_0001);
        rd(8'h48, v);
        check("R9 later clear", v, 32'h0000_0000);
        @(negedge clk);
        pin_in = '0;
        settle(4);

        // R10 wake detection only on armed lines during force
        wr(8'h40, 32'h0);
        wr(8'h44, 32'h0);
        wr(8'h50, 32'h0000_0030);
        wr(8'h1C, 32'h0000_0020);
        @(negedge clk);
        sleep_force = 1'b1;
        pin_in = 32'h0000_0030;
        settle(3);
        rd(8'h58, v);
        check("R10 wake set on armed line4 only", v, 32'h0000_0010);
        check("R10 wake_irq high", {31'd0, wake_irq}, 32'd1);
        wr(8'h58, 32'h0000_0010);
        rd(8'h58, v);
        check("R10 wake cleared", v, 32'h0000_0000);
        check("R10 wake_irq low", {31'd0, wake_irq}, 32'd0);
        @(negedge clk);
        sleep_force = 1'b0;
        pin_in = '0;
        settle(4);
        pin_in = 32'h0000_0030;
        settle(4);
        rd(8'h58, v);
        check("R10 no wake while force low", v, 32'h0000_0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule